// File: doc/BRIEF.md
# Port Statistics Snapshot Unit

This block keeps a set of event counters for each switch port and lets a host read them in a consistent way. Every port owns `NUM_CTRS` live counters. Each counter advances by one on a cycle in which its increment pulse is high, and it stops at all-ones instead of wrapping. Increment pulses are always taken: there is no back-pressure on them, and a pulse is never dropped, even while a capture is running.

The host works through three 16-bit registers, picked with `host_sel`. Writing a capture command to the operation register copies the whole counter set of one port into a single capture bank. The copy takes one counter per cycle. Writing a read command then loads one captured counter into the high-result and low-result registers. Bit 15 of the operation register is a busy flag that the host polls. The host writes no command while busy is set, and any command written during that time is discarded. A 64-bit statistic is spread over two neighbouring indices, the low word at the even index and the high word at the next one, and the host joins them after two reads.

Top module: `port_stats_snap`

## Requirements
- R1: After reset, all three host registers read 0x0000 and every capture-bank entry holds zero.
- R2: A write to the operation register (select 0) whose bits 15:8 are 0xDC and whose bits 7:0 name a port below `NUM_PORTS` starts a capture. Bit 15 of the operation register reads 1 for exactly `NUM_CTRS` cycles from the next cycle, then reads 0.
- R3: A write to the operation register whose bits 15:8 are 0xCC and whose bits 7:0 name an index below `NUM_CTRS` sets busy for exactly one cycle. After that, select 1 reads bits 31:16 of that captured counter and select 2 reads bits 15:0.
- R4: The capture bank changes only when a capture runs. Increments that arrive after a capture do not appear in later reads until the next capture.
- R5: Live counters keep counting while a capture is in progress. No pulse is lost.
- R6: A live counter that holds all-ones stays at all-ones when it receives more increments.
- R7: An operation register write that arrives while busy reads 1 is discarded. It does not stretch the busy time, and it does not change the captured port.
- R8: A write with any other opcode, or with a port or index out of range, or a write to select 1, 2 or 3, leaves busy at 0 and leaves the result registers and the capture bank unchanged.
- R9: Reads of index 2k and then 2k+1 give the low and high 32-bit halves of a 64-bit statistic as two separate captured counters.
- R10: A capture of port p takes only port p's counters. Counters of other ports do not show up in the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_pulse | input | NUM_PORTS*NUM_CTRS | Increment pulse for each live counter. Bit port*NUM_CTRS+index |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_sel | input | 2 | Register select: 0 operation, 1 result high, 2 result low, 3 reads zero |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Combinational read data of the selected register |

## Verification
The counters are loaded with a different count per port and per index, so a capture of the wrong port or a swapped index gives a wrong value on readback. One counter is driven with more than 65536 pulses so that the high-result register carries a non-zero value. Other stimulus targets particular behaviours: pulses placed inside a capture window check that none are lost, pulses after a capture check that the bank stays frozen, commands written during busy check that they are discarded, and malformed commands check that nothing changes. A narrow-counter instance is driven past its maximum to check that it holds at all-ones.

// File: rtl/stats_snap_pkg.sv
package stats_snap_pkg;
  localparam logic [7:0] OPC_CAPTURE = 8'hDC;
  localparam logic [7:0] OPC_READ    = 8'hCC;

  localparam logic [1:0] SEL_OP = 2'd0;
  localparam logic [1:0] SEL_HI = 2'd1;
  localparam logic [1:0] SEL_LO = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_COPY = 2'd1,
    ST_READ = 2'd2
  } snap_state_e;
endpackage

// File: rtl/stat_live_bank.sv
module stat_live_bank #(
  parameter int NUM_PORTS = 4,
  parameter int NUM_CTRS  = 8,
  parameter int CTR_W     = 32
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_PORTS*NUM_CTRS-1:0]         inc_pulse,
  output logic [NUM_PORTS*NUM_CTRS-1:0][CTR_W-1:0] live
);
  localparam int TOTAL = NUM_PORTS * NUM_CTRS;

  for (genvar g = 0; g < TOTAL; g++) begin : g_ctr
    logic [CTR_W-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt_q <= '0;
      else if (inc_pulse[g] && (cnt_q != {CTR_W{1'b1}}))
        cnt_q <= cnt_q + 1'b1;
    end
    assign live[g] = cnt_q;
  end
endmodule

// File: rtl/stat_capture_bank.sv
module stat_capture_bank #(
  parameter int NUM_PORTS = 4,
  parameter int NUM_CTRS  = 8,
  parameter int CTR_W     = 32,
  localparam int PW  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int CIW = (NUM_CTRS > 1) ? $clog2(NUM_CTRS) : 1
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic [NUM_PORTS*NUM_CTRS-1:0][CTR_W-1:0] live,
  input  logic                                     copy_en,
  input  logic [PW-1:0]                            cap_port,
  input  logic [CIW-1:0]                           copy_idx,
  input  logic [CIW-1:0]                           rd_idx,
  output logic [CTR_W-1:0]                         rd_val
);
  localparam int TOTAL = NUM_PORTS * NUM_CTRS;

  logic [CTR_W-1:0] src;
  logic [NUM_CTRS-1:0][CTR_W-1:0] bank_q;

  // select the live counter of the port being captured
  always_comb begin
    src = '0;
    for (int i = 0; i < TOTAL; i++) begin
      if (i == (int'(cap_port) * NUM_CTRS + int'(copy_idx)))
        src = live[i];
    end
  end

  for (genvar g = 0; g < NUM_CTRS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        bank_q[g] <= '0;
      else if (copy_en && (int'(copy_idx) == g))
        bank_q[g] <= src;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_CTRS; i++) begin
      if (int'(rd_idx) == i)
        rd_val = bank_q[i];
    end
  end
endmodule

// File: rtl/stat_op_ctrl.sv
module stat_op_ctrl
  import stats_snap_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NUM_CTRS  = 8,
  localparam int PW  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int CIW = (NUM_CTRS > 1) ? $clog2(NUM_CTRS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_wr,
  input  logic [1:0]     host_sel,
  input  logic [15:0]    host_wdata,
  output logic           busy,
  output logic           copy_en,
  output logic [PW-1:0]  cap_port,
  output logic [CIW-1:0] copy_idx,
  output logic [CIW-1:0] rd_idx,
  output logic           load_res
);
  snap_state_e st_q;
  logic [7:0]  opc;
  logic [7:0]  arg;
  logic        op_wr;
  logic        want_cap;
  logic        want_rd;

  assign opc      = host_wdata[15:8];
  assign arg      = host_wdata[7:0];
  assign op_wr    = host_wr && (host_sel == SEL_OP) && (st_q == ST_IDLE);
  assign want_cap = op_wr && (opc == OPC_CAPTURE) && (int'(arg) < NUM_PORTS);
  assign want_rd  = op_wr && (opc == OPC_READ) && (int'(arg) < NUM_CTRS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cap_port <= '0;
      copy_idx <= '0;
      rd_idx   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (want_cap) begin
            cap_port <= arg[PW-1:0];
            copy_idx <= '0;
            st_q     <= ST_COPY;
          end else if (want_rd) begin
            rd_idx <= arg[CIW-1:0];
            st_q   <= ST_READ;
          end
        end
        ST_COPY: begin
          if (int'(copy_idx) == NUM_CTRS - 1)
            st_q <= ST_IDLE;
          else
            copy_idx <= copy_idx + 1'b1;
        end
        ST_READ: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign copy_en  = (st_q == ST_COPY);
  assign load_res = (st_q == ST_READ);
endmodule

// File: rtl/port_stats_snap.sv
module port_stats_snap
  import stats_snap_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NUM_CTRS  = 8,
  parameter int CTR_W     = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PORTS*NUM_CTRS-1:0] inc_pulse,
  input  logic                          host_wr,
  input  logic [1:0]                    host_sel,
  input  logic [15:0]                   host_wdata,
  output logic [15:0]                   host_rdata
);
  localparam int PW  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int CIW = (NUM_CTRS > 1) ? $clog2(NUM_CTRS) : 1;

  logic [NUM_PORTS*NUM_CTRS-1:0][CTR_W-1:0] live;
  logic           busy;
  logic           copy_en;
  logic           load_res;
  logic [PW-1:0]  cap_port;
  logic [CIW-1:0] copy_idx;
  logic [CIW-1:0] rd_idx;
  logic [CTR_W-1:0] rd_val;
  logic [31:0]    rd_ext;
  logic [31:0]    res_q;

  stat_live_bank #(
    .NUM_PORTS(NUM_PORTS), .NUM_CTRS(NUM_CTRS), .CTR_W(CTR_W)
  ) u_live (
    .clk(clk), .rst_n(rst_n), .inc_pulse(inc_pulse), .live(live)
  );

  stat_op_ctrl #(
    .NUM_PORTS(NUM_PORTS), .NUM_CTRS(NUM_CTRS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .busy(busy), .copy_en(copy_en),
    .cap_port(cap_port), .copy_idx(copy_idx), .rd_idx(rd_idx),
    .load_res(load_res)
  );

  stat_capture_bank #(
    .NUM_PORTS(NUM_PORTS), .NUM_CTRS(NUM_CTRS), .CTR_W(CTR_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .live(live), .copy_en(copy_en),
    .cap_port(cap_port), .copy_idx(copy_idx), .rd_idx(rd_idx),
    .rd_val(rd_val)
  );

  always_comb begin
    rd_ext = '0;
    rd_ext[CTR_W-1:0] = rd_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      res_q <= '0;
    else if (load_res)
      res_q <= rd_ext;
  end

  always_comb begin
    unique case (host_sel)
      SEL_OP:  host_rdata = {busy, 15'b0};
      SEL_HI:  host_rdata = res_q[31:16];
      SEL_LO:  host_rdata = res_q[15:0];
      default: host_rdata = 16'h0000;
    endcase
  end
endmodule

// File: rtl/port_stats_snap_chk.sv
module port_stats_snap_chk #(
  parameter int NUM_PORTS = 4,
  parameter int NUM_CTRS  = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr,
  input logic [1:0]  host_sel,
  input logic [15:0] host_wdata,
  input logic        busy,
  input logic [31:0] res_q
);
  logic idle_op_wr;
  logic [15:0] busy_run;

  assign idle_op_wr = host_wr && (host_sel == 2'd0) && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n)
      busy_run <= '0;
    else if (busy)
      busy_run <= busy_run + 1'b1;
    else
      busy_run <= '0;
  end

  // R2: an accepted capture raises busy on the next cycle
  p_capture_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_op_wr && host_wdata[15:8] == 8'hDC && int'(host_wdata[7:0]) < NUM_PORTS) |=> busy);

  // R2: busy never outlasts one counter set copy
  p_busy_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(busy_run) <= NUM_CTRS);

  // R3: an accepted read is busy for exactly one cycle
  p_read_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_op_wr && host_wdata[15:8] == 8'hCC && int'(host_wdata[7:0]) < NUM_CTRS)
      |=> busy ##1 !busy);

  // R4: result registers move only at the end of an operation
  p_result_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_q) |-> $past(busy));

  // R8: unknown opcodes never start an operation
  p_bad_opcode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_op_wr && host_wdata[15:8] != 8'hDC && host_wdata[15:8] != 8'hCC) |=> !busy);
endmodule

bind port_stats_snap port_stats_snap_chk #(
  .NUM_PORTS(NUM_PORTS), .NUM_CTRS(NUM_CTRS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
  .host_wdata(host_wdata), .busy(busy), .res_q(res_q)
);

// File: tb/tb_port_stats_snap.sv
module tb_port_stats_snap;
  localparam int NP = 4;
  localparam int NC = 8;
  localparam int SNP = 2;
  localparam int SNC = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        which;
  logic        host_wr;
  logic [1:0]  host_sel;
  logic [15:0] host_wdata;
  logic [NP*NC-1:0]   inc_m;
  logic [SNP*SNC-1:0] inc_s;
  logic [15:0] rd_m, rd_s, rd;

  assign rd = which ? rd_s : rd_m;

  port_stats_snap #(.NUM_PORTS(NP), .NUM_CTRS(NC), .CTR_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .inc_pulse(inc_m), .host_wr(host_wr && !which),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(rd_m)
  );

  port_stats_snap #(.NUM_PORTS(SNP), .NUM_CTRS(SNC), .CTR_W(4)) dut_sat (
    .clk(clk), .rst_n(rst_n), .inc_pulse(inc_s), .host_wr(host_wr && which),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(rd_s)
  );

  int vecs = 0;
  int fails = 0;
  int cnt[NP*NC];
  logic [31:0] exp_q[$];
  logic [31:0] act_q[$];
  string       tag_q[$];
  logic [31:0] last_exp;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected and observed results in order and compares
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        logic [31:0] a;
        logic [31:0] e;
        string t;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " result high"}, {16'h0, a[31:16]}, {16'h0, e[31:16]});
        check({t, " result low"},  {16'h0, a[15:0]},  {16'h0, e[15:0]});
      end
    end
  end

  task automatic op_write(logic [15:0] v);
    host_sel   = 2'd0;
    host_wdata = v;
    host_wr    = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic capture(int port, int len, bit inject, string tag);
    int n;
    op_write(16'hDC00 | 16'(port));
    n = 0;
    while (rd[15] === 1'b1 && n < 100) begin
      n++;
      if (inject && n == 2) begin
        host_wdata = 16'hCC03;
        host_wr    = 1'b1;
      end else if (inject && n == 3) begin
        host_wdata = 16'hDC00;
      end else begin
        host_wr = 1'b0;
      end
      @(negedge clk);
    end
    host_wr = 1'b0;
    check({tag, " busy cycles"}, 32'(n), 32'(len));
  endtask

  // driver: queues the expected value, runs the read, hands the result to the monitor
  task automatic do_read(int idx, logic [31:0] exp, string tag);
    logic [15:0] hi;
    logic [15:0] lo;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    last_exp = exp;
    op_write(16'hCC00 | 16'(idx));
    check({tag, " busy set"}, {31'b0, rd[15]}, 32'd1);
    @(negedge clk);
    check({tag, " busy clear"}, {31'b0, rd[15]}, 32'd0);
    host_sel = 2'd1; #1 hi = rd;
    host_sel = 2'd2; #1 lo = rd;
    host_sel = 2'd0;
    act_q.push_back({hi, lo});
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; which = 1'b0; host_wr = 1'b0; host_sel = 2'd0;
    host_wdata = 16'h0; inc_m = '0; inc_s = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    host_sel = 2'd0; #1 check("R1 op reg", {16'h0, rd}, 32'h0);
    host_sel = 2'd1; #1 check("R1 result high", {16'h0, rd}, 32'h0);
    host_sel = 2'd2; #1 check("R1 result low", {16'h0, rd}, 32'h0);
    host_sel = 2'd0;
    do_read(5, 32'h0, "R1 bank entry");

    // distinct counts per port and index
    for (int i = 0; i < NP*NC; i++) cnt[i] = 3 * (i / NC) + (i % NC) + 1;
    for (int n = 0; n < 20; n++) begin
      for (int i = 0; i < NP*NC; i++) inc_m[i] = (n < cnt[i]);
      @(negedge clk);
    end
    inc_m = '0;

    // R2 / R3 / R10: capture port 2 and read every index
    capture(2, NC, 1'b0, "R2 capture port 2");
    for (int k = 0; k < NC; k++) do_read(k, 32'(cnt[2*NC + k]), "R3 R10 port 2 read");

    capture(0, NC, 1'b0, "R2 capture port 0");
    do_read(3, 32'(cnt[3]), "R10 port 0 index 3");
    do_read(4, 32'(cnt[4]), "R9 low half");
    do_read(5, 32'(cnt[5]), "R9 high half");

    // R4: later increments stay out of the bank until recaptured
    inc_m[3] = 1'b1;
    repeat (5) @(negedge clk);
    inc_m[3] = 1'b0;
    do_read(3, 32'(cnt[3]), "R4 bank frozen");
    cnt[3] += 5;
    capture(0, NC, 1'b0, "R4 recapture");
    do_read(3, 32'(cnt[3]), "R4 bank refreshed");

    // R5: pulses inside a capture window are not lost
    fork
      capture(3, NC, 1'b0, "R5 capture port 3");
      begin
        inc_m[3*NC + 7] = 1'b1;
        repeat (4) @(negedge clk);
        inc_m[3*NC + 7] = 1'b0;
      end
    join
    cnt[3*NC + 7] += 4;
    capture(3, NC, 1'b0, "R5 recapture port 3");
    do_read(7, 32'(cnt[3*NC + 7]), "R5 no lost pulse");

    // R7: commands during busy are discarded
    capture(1, NC, 1'b1, "R7 capture port 1");
    do_read(3, 32'(cnt[1*NC + 3]), "R7 port kept");

    // R8: malformed commands and result register writes change nothing
    op_write(16'hAB01);
    check("R8 bad opcode busy", {31'b0, rd[15]}, 32'd0);
    op_write(16'hCC00 | 16'(NC));
    check("R8 index range busy", {31'b0, rd[15]}, 32'd0);
    op_write(16'hDC00 | 16'(NP));
    check("R8 port range busy", {31'b0, rd[15]}, 32'd0);
    host_sel = 2'd1; host_wdata = 16'h1234; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    host_sel = 2'd1; #1 check("R8 result high kept", {16'h0, rd}, {16'h0, last_exp[31:16]});
    host_sel = 2'd2; #1 check("R8 result low kept", {16'h0, rd}, {16'h0, last_exp[15:0]});
    host_sel = 2'd0;
    do_read(3, 32'(cnt[1*NC + 3]), "R8 bank kept");

    // R3: high result word carries bits 31:16
    inc_m[6] = 1'b1;
    repeat (70000) @(negedge clk);
    inc_m[6] = 1'b0;
    cnt[6] += 70000;
    capture(0, NC, 1'b0, "R3 capture for high word");
    do_read(6, 32'(cnt[6]), "R3 high word");

    // R6: narrow counters saturate
    which = 1'b1;
    inc_s[0] = 1'b1;
    inc_s[1] = 1'b1;
    repeat (3) @(negedge clk);
    inc_s[1] = 1'b0;
    repeat (17) @(negedge clk);
    inc_s[0] = 1'b0;
    capture(0, SNC, 1'b0, "R6 capture");
    do_read(0, 32'd15, "R6 saturated");
    do_read(1, 32'd3, "R6 unsaturated neighbour");
    which = 1'b0;

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule